// File: doc/BRIEF.md
# Timer Status Flag Unit

This block holds the event flags of a 16-bit timer/counter. A small counter is built in so that the flags have real events to record. The counter advances only on clocks where the timer tick enable is high. It can run freely, or it can clear when it reaches a TOP value. TOP comes from compare register A or from the capture register. Two compare channels, A and B, raise their flag one timer tick after their match. A capture register copies the count on an external strobe.

The four flags appear in an 8-bit status byte. Software reads that byte at any time and clears flags by writing ones to them. An interrupt controller clears a flag by pulsing that flag's acknowledge line. Each flag drives an interrupt request through its own enable bit. Each compare channel also has an event pulse output for a downstream waveform stage. A forced-compare strobe drives that pulse and never touches a flag.

Four-bit vectors `irq_en`, `irq_ack` and `irq` use one bit order: bit 0 is overflow, bit 1 is compare A, bit 2 is compare B and bit 3 is capture. The `mode` input selects how the counter runs:
- 0: free running.
- 1: clear at compare A.
- 2: clear at the capture register.
- 3: free running.

Top module: `tmr_flag_unit`

## Requirements
- R1: `stat_rdata` carries the capture flag at bit 5, compare B at bit 2, compare A at bit 1 and overflow at bit 0. Bits 7:6 and 4:3 always read zero. Writing ones to those bits changes nothing.
- R2: After reset, all four flags, the count and the capture register are zero.
- R3: A compare flag sets at the first tick that follows a tick in which `count` equalled that channel's compare value.
- R4: `force_a` or `force_b` drives `cmp_evt` bit 0 or bit 1 in the same cycle. These strobes never set a compare flag.
- R5: In modes other than 2, a tick with `cap_strobe` high copies the current count into `cap_val` and sets the capture flag.
- R6: In mode 2, the counter clears to zero on a tick at `count == cap_val`, and that tick sets the capture flag. `cap_strobe` is ignored and `cap_val` holds.
- R7: A tick at count 16'hFFFF wraps the count to zero and sets the overflow flag. In mode 1, a tick at `count == cmp_a` clears the count to zero.
- R8: A `stat_wr` with a one in a flag's bit position clears that flag. A zero in that position leaves the flag unchanged.
- R9: A pulse on an `irq_ack` bit clears the matching flag.
- R10: If a set event and a clear (write-one or acknowledge) arrive on the same clock, the flag ends up set.
- R11: Each `irq` bit equals its flag ANDed with its `irq_en` bit.
- R12: Flags set and the count advances only on clocks where `tick` is high. Clears take effect on any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable |
| mode | input | 2 | Counter mode: 0 free, 1 clear at A, 2 clear at capture, 3 free |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| cap_strobe | input | 1 | External capture strobe |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| stat_wr | input | 1 | Status byte write strobe |
| stat_wdata | input | 8 | Status write data; a one clears a flag |
| irq_en | input | 4 | Interrupt enable mask |
| irq_ack | input | 4 | Interrupt acknowledge pulses |
| stat_rdata | output | 8 | Status byte |
| irq | output | 4 | Interrupt requests |
| count | output | 16 | Counter value |
| cap_val | output | 16 | Capture register |
| cmp_evt | output | 2 | Compare event pulses (bit 0 A, bit 1 B) |

## Verification
The risk is a flag that is set or cleared at the wrong moment. Such a flag shows up in `stat_rdata` and `irq` on the clock right after the faulty edge. A compare pending register that fires one tick early or late moves a compare flag by a whole tick. That error is visible at the very next tick after the match. A lost collision or a bad TOP value shows in `count` returning to zero at the wrong place, within one counting period.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'b00,
    MODE_CLR_A   = 2'b01,
    MODE_CLR_CAP = 2'b10,
    MODE_SPARE   = 2'b11
  } tmr_mode_e;

  localparam int NFLAGS   = 4;
  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_CAP  = 3;

  // status byte positions; software decodes these
  localparam int POS_OVF  = 0;
  localparam int POS_CMPA = 1;
  localparam int POS_CMPB = 2;
  localparam int POS_CAP  = 5;

  function automatic logic [7:0] pack_status(input logic [NFLAGS-1:0] f);
    logic [7:0] s;
    s           = 8'h00;
    s[POS_OVF]  = f[FLG_OVF];
    s[POS_CMPA] = f[FLG_CMPA];
    s[POS_CMPB] = f[FLG_CMPB];
    s[POS_CAP]  = f[FLG_CAP];
    return s;
  endfunction

  function automatic logic [NFLAGS-1:0] status_to_clear(input logic [7:0] wd);
    logic [NFLAGS-1:0] c;
    c[FLG_OVF]  = wd[POS_OVF];
    c[FLG_CMPA] = wd[POS_CMPA];
    c[FLG_CMPB] = wd[POS_CMPB];
    c[FLG_CAP]  = wd[POS_CAP];
    return c;
  endfunction

  // set has priority so that no event is dropped
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr_mode,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         top_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] count_next(input logic [W-1:0] c, input logic at_top);
    return at_top ? '0 : c + 1'b1;
  endfunction

  assign top_evt = tick & clr_mode & (count == top_val);
  assign ovf_evt = tick & (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count_next(count, top_evt);
  end

  assert_top_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_evt |=> (count == '0));
  assert_ovf_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count == '0));
  assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp_val,
  input  logic         force_i,
  output logic         set_evt,
  output logic         evt_o
);
  logic pend;

  // match recorded on one tick, reported on the next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (tick) pend <= (count == cmp_val);
  end

  assign set_evt = tick & pend;
  assign evt_o   = set_evt | force_i;

  assert_force_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> evt_o);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         strobe,
  input  logic         use_top,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         cap_evt
);
  logic latch_evt, top_hit;

  assign latch_evt = tick & strobe & ~use_top;
  assign top_hit   = tick & use_top & (count == cap_val);
  assign cap_evt   = latch_evt | top_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_val <= '0;
    else if (latch_evt) cap_val <= count;
  end

  assert_cap_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && strobe && !use_top) |=> (cap_val == $past(count)));
  assert_cap_hold_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    use_top |=> $stable(cap_val));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NFLAGS-1:0] set_evt,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [NFLAGS-1:0] ack,
  output logic [NFLAGS-1:0] flags
);
  logic [NFLAGS-1:0] wr_clr;
  assign wr_clr = status_to_clear(wr_data) & {NFLAGS{wr_en}};

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], set_evt[i], wr_clr[i] | ack[i]);
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    assert_wr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr[i] && !set_evt[i]) |=> !flags[i]);
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_evt[i]) |=> !flags[i]);
    assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !flags[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         cap_strobe,
  input  logic         force_a,
  input  logic         force_b,
  input  logic         stat_wr,
  input  logic [7:0]   stat_wdata,
  input  logic [3:0]   irq_en,
  input  logic [3:0]   irq_ack,
  output logic [7:0]   stat_rdata,
  output logic [3:0]   irq,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic [1:0]   cmp_evt
);
  tmr_mode_e         mode_e;
  logic              clr_mode, use_cap_top;
  logic [W-1:0]      top_val;
  logic              ovf_evt, top_evt, cmpa_set, cmpb_set, cap_evt;
  logic [NFLAGS-1:0] set_evt, flags;

  assign mode_e      = tmr_mode_e'(mode);
  assign use_cap_top = (mode_e == MODE_CLR_CAP);
  assign clr_mode    = (mode_e == MODE_CLR_A) || use_cap_top;
  assign top_val     = use_cap_top ? cap_val : cmp_a;

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr_mode(clr_mode),
    .top_val(top_val), .count(count), .ovf_evt(ovf_evt), .top_evt(top_evt)
  );

  tmr_compare #(.W(W)) u_cmp_a (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cmp_val(cmp_a),
    .force_i(force_a), .set_evt(cmpa_set), .evt_o(cmp_evt[0])
  );

  tmr_compare #(.W(W)) u_cmp_b (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cmp_val(cmp_b),
    .force_i(force_b), .set_evt(cmpb_set), .evt_o(cmp_evt[1])
  );

  tmr_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(cap_strobe),
    .use_top(use_cap_top), .count(count), .cap_val(cap_val), .cap_evt(cap_evt)
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLG_OVF]  = ovf_evt;
    set_evt[FLG_CMPA] = cmpa_set;
    set_evt[FLG_CMPB] = cmpb_set;
    set_evt[FLG_CAP]  = cap_evt;
  end

  tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_evt(set_evt),
    .wr_en(stat_wr), .wr_data(stat_wdata), .ack(irq_ack), .flags(flags)
  );

  assign stat_rdata = pack_status(flags);
  assign irq        = flags & irq_en;

  assert_top_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_cap_top && top_evt) |-> cap_evt);
  assert_irq_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~irq_en) == 4'b0000);
endmodule

// File: tb/tmr_flag_unit_bench.sv
`timescale 1ns/1ps
module tmr_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] cmp_a = 16'd0, cmp_b = 16'd0;
  logic        cap_strobe = 1'b0, force_a = 1'b0, force_b = 1'b0;
  logic        stat_wr = 1'b0;
  logic [7:0]  stat_wdata = 8'h00;
  logic [3:0]  irq_en = 4'h0, irq_ack = 4'h0;
  logic [7:0]  stat_rdata;
  logic [3:0]  irq;
  logic [15:0] count, cap_val;
  logic [1:0]  cmp_evt;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_flag_unit u_tmr_flag_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cap_strobe(cap_strobe), .force_a(force_a), .force_b(force_b), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .irq_en(irq_en), .irq_ack(irq_ack), .stat_rdata(stat_rdata),
    .irq(irq), .count(count), .cap_val(cap_val), .cmp_evt(cmp_evt)
  );

  // reference: flags in order ovf, A, B, cap
  logic [15:0] m_cnt, m_cap;
  logic        m_pa, m_pb;
  logic [3:0]  m_fl;

  function automatic logic [7:0] status_of(input logic [3:0] f);
    return {2'b00, f[3], 2'b00, f[2], f[1], f[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [3:0]  s, c;
    logic        at_top;
    logic [15:0] tv;
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_pa = 0; m_pb = 0; m_fl = 0;
    end else begin
      s = 0;
      c = irq_ack | (stat_wr ? {stat_wdata[5], stat_wdata[2], stat_wdata[1], stat_wdata[0]} : 4'h0);
      tv = (mode == 2'b10) ? m_cap : cmp_a;
      at_top = (mode == 2'b01 || mode == 2'b10) && (m_cnt == tv);
      if (tick) begin
        s[1] = m_pa; s[2] = m_pb; s[0] = (m_cnt == 16'hFFFF);
        if (mode == 2'b10) s[3] = (m_cnt == m_cap);
        else if (cap_strobe) begin s[3] = 1; m_cap = m_cnt; end
        m_pa = (m_cnt == cmp_a);
        m_pb = (m_cnt == cmp_b);
        m_cnt = at_top ? 16'h0 : m_cnt + 16'h1;
      end
      m_fl = s | (m_fl & ~c);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(stat_rdata == status_of(m_fl), "R1/R3/R8/R9/R10/R12 status vs model", stat_rdata, status_of(m_fl));
    chk(irq == (m_fl & irq_en), "R11 irq vs model", irq, m_fl & irq_en);
    chk(count == m_cnt, "R7 count vs model", count, m_cnt);
    chk(cap_val == m_cap, "R5/R6 cap vs model", cap_val, m_cap);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); model_cmp();
  endtask

  task automatic idle();
    stat_wr = 0; stat_wdata = 0; irq_ack = 0; cap_strobe = 0; force_a = 0; force_b = 0;
  endtask

  task automatic clear_all();
    idle(); tick = 0; stat_wr = 1; stat_wdata = 8'hFF; step(); idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(stat_rdata == 8'h00, "R2 reset status", stat_rdata, 0);
    chk(count == 16'h0, "R2 reset count", count, 0);
    chk(irq == 4'h0 && cap_val == 0, "R2 reset irq/cap", {irq, cap_val}, 0);
    rst_n = 1; @(negedge clk);

    // R3: clear at A=5, B=3, tick every clock
    mode = 2'b01; cmp_a = 16'd5; cmp_b = 16'd3; tick = 1;
    repeat (4) step();
    chk(stat_rdata[2] == 1'b0, "R3 B not yet set", stat_rdata[2], 0);
    step();
    chk(stat_rdata[2] == 1'b1, "R3 B set one tick after match", stat_rdata[2], 1);
    chk(count == 16'd5, "R7 count at 5", count, 5);

    // R12 / R10: pending A held across idle clocks, then collides with a write-one
    clear_all();
    tick = 1; step(); tick = 0;
    chk(count == 16'd0, "R7 clear at A", count, 0);
    chk(stat_rdata[1] == 1'b0, "R3 A pending only", stat_rdata[1], 0);
    repeat (3) step();
    chk(stat_rdata[1] == 1'b0, "R12 no set without tick", stat_rdata[1], 0);
    tick = 1; stat_wr = 1; stat_wdata = 8'h02; step(); idle(); tick = 0;
    chk(stat_rdata[1] == 1'b1, "R10 set wins over write-one", stat_rdata[1], 1);
    irq_en = 4'b0010; #1;
    chk(irq == 4'b0010, "R11 irq with enable", irq, 4'b0010);
    irq_en = 4'b0000; #1;
    chk(irq == 4'b0000, "R11 irq masked", irq, 0);
    // R8 write zero / R1 reserved bits
    stat_wr = 1; stat_wdata = 8'h00; step();
    chk(stat_rdata == 8'h02, "R8 write zero keeps flag", stat_rdata, 8'h02);
    stat_wdata = 8'hD8; step();
    chk(stat_rdata == 8'h02, "R1 reserved writes ignored", stat_rdata, 8'h02);
    idle(); irq_ack = 4'b0010; step(); idle();
    chk(stat_rdata == 8'h00, "R9 ack clears", stat_rdata, 0);

    // R4 forced compare
    force_a = 1; force_b = 1; #1;
    chk(cmp_evt == 2'b11, "R4 force pulses event", cmp_evt, 3);
    step(); idle();
    chk(stat_rdata == 8'h00, "R4 force sets no flag", stat_rdata, 0);

    // R5 capture in free mode
    mode = 2'b00; tick = 1;
    while (count != 16'd30) step();
    cap_strobe = 1; step(); cap_strobe = 0;
    chk(cap_val == 16'd30, "R5 capture value", cap_val, 30);
    chk(stat_rdata[5] == 1'b1, "R5 capture flag", stat_rdata[5], 1);
    clear_all();

    // R6 capture register as TOP
    mode = 2'b01; cmp_a = 16'd40; tick = 1;
    while (count != 16'd0) step();
    mode = 2'b10; cap_strobe = 1;
    while (count != 16'd30) step();
    chk(stat_rdata[5] == 1'b0, "R6 no flag before TOP", stat_rdata[5], 0);
    step(); cap_strobe = 0;
    chk(stat_rdata[5] == 1'b1, "R6 flag at TOP", stat_rdata[5], 1);
    chk(count == 16'd0, "R6 clear at TOP", count, 0);
    chk(cap_val == 16'd30, "R6 strobe ignored", cap_val, 30);
    clear_all();

    // R7 overflow
    mode = 2'b00; cmp_a = 16'd3; cmp_b = 16'd4; tick = 1;
    while (count != 16'hFFFF) step();
    chk(stat_rdata[0] == 1'b0, "R7 no overflow before wrap", stat_rdata[0], 0);
    step();
    chk(stat_rdata[0] == 1'b1 && count == 0, "R7 overflow on wrap", {stat_rdata[0], count}, 17'h10000);
    repeat (5) step();
    cap_strobe = 1; step(); cap_strobe = 0;
    chk(stat_rdata == 8'h27, "R1 full status layout", stat_rdata, 8'h27);
    clear_all();

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      mode = 2'(ph); cmp_a = 16'(8 + $urandom % 56); cmp_b = 16'($urandom % 64);
      irq_en = 4'($urandom);
      for (int k = 0; k < 3000; k++) begin
        tick = ($urandom % 4) != 0;
        cap_strobe = ($urandom % 8) == 0;
        force_a = ($urandom % 16) == 0;
        force_b = ($urandom % 16) == 0;
        stat_wr = ($urandom % 8) == 0;
        stat_wdata = 8'($urandom);
        irq_ack = (($urandom % 12) == 0) ? 4'($urandom) : 4'h0;
        step();
      end
      idle();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule